// File: doc/BRIEF.md
# Packed SIMD Saturating Add/Subtract Unit

This unit adds or subtracts two 64-bit words that each hold several independent integers packed side by side. Each operation selects one of three lane widths: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. No carry or borrow passes from one lane into the next, so in the 8-bit layout eight separate sums are produced in one operation.

Each operation also selects one of three arithmetic modes. Wraparound mode keeps the low bits of each lane result. Signed saturation clamps a lane that overflows to the most positive or most negative two's-complement value of that lane. Unsigned saturation clamps to zero or to all ones. The result is registered and appears one clock after the operands are presented with the valid strobe.

Top module: `simd_sat_adder`

## Requirements
- R1: With `lane_sel`=0, each byte lane k (bits 8k+7..8k, lane 0 in the least significant bits) holds the wrapped sum or difference of the matching operand bytes, and no carry or borrow passes between bytes.
- R2: With `lane_sel`=1, each 16-bit lane is computed on its own: carries pass between the two bytes of a lane but never into the next lane.
- R3: With `lane_sel`=2 or 3, the word is treated as two independent 32-bit lanes.
- R4: With `arith_mode`=0 or 3 (wraparound), each lane holds (a+b) or (a-b) modulo 2^lane width. `op_sub`=1 selects subtraction and 0 selects addition.
- R5: With `arith_mode`=1 (signed saturation), a lane whose true signed result is above the lane maximum gives 0x7F.., and one below the lane minimum gives 0x80..; any other lane gives the exact result.
- R6: With `arith_mode`=2 (unsigned saturation), an add that exceeds the lane range gives all ones, and a subtract that would go below zero gives zero; any other lane gives the exact result.
- R7: `out_valid` is `in_valid` delayed by one clock. `out_data` takes the result of the operation on the clock edge at which `in_valid` is high and holds its value on every edge at which `in_valid` is low.
- R8: While `rst_n` is low, `out_valid` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand (the subtrahend when subtracting) |
| lane_sel | input | 2 | 0: 8-bit lanes, 1: 16-bit lanes, 2 or 3: 32-bit lanes |
| op_sub | input | 1 | 1: a-b, 0: a+b |
| arith_mode | input | 2 | 0 or 3: wraparound, 1: signed saturation, 2: unsigned saturation |
| out_valid | output | 1 | The result register holds a new result |
| out_data | output | 64 | Packed result |

## Verification
Every result is due exactly one clock after the edge that captures its operands. The bench drives each operation on a falling edge. It then waits one full cycle and samples `out_valid` and `out_data` on the next falling edge, which lies away from the capturing rising edge. The behavioural model computes the expected value lane by lane with wide integers and explicit clamp limits. On cycles with `in_valid` low, the model expects `out_valid` low and the previous result held, so that every cycle is compared against a value due that same cycle.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    LANE_X8   = 2'd0,
    LANE_X16  = 2'd1,
    LANE_X32  = 2'd2,
    LANE_X32B = 2'd3
  } lane_sel_e;

  typedef enum logic [1:0] {
    ARITH_WRAP  = 2'd0,
    ARITH_SSAT  = 2'd1,
    ARITH_USAT  = 2'd2,
    ARITH_WRAPB = 2'd3
  } arith_e;

  // Number of byte slices making up one lane for a given lane select.
  function automatic int unsigned slices_per_lane(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // True when slice k is the least significant slice of its lane.
  function automatic logic is_lane_start(input int unsigned k, input logic [1:0] sel);
    return (k % slices_per_lane(sel)) == 0;
  endfunction

  // Index of the most significant slice of the lane that holds slice k.
  function automatic int unsigned lane_top_slice(input int unsigned k, input logic [1:0] sel);
    int unsigned n;
    n = slices_per_lane(sel);
    return k - (k % n) + n - 1;
  endfunction

  // Slice value that signed saturation writes: the top slice carries the sign.
  function automatic logic [7:0] ssat_slice(input logic neg, input logic is_top);
    if (is_top) return neg ? 8'h80 : 8'h7F;
    else        return neg ? 8'h00 : 8'hFF;
  endfunction

endpackage

// File: rtl/simd_add_slice.sv
module simd_add_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         a_msb,
  output logic         bx_msb
);
  logic [W-1:0] b_eff;
  logic [W:0]   total;

  assign b_eff  = b ^ {W{sub}};
  assign total  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum    = total[W-1:0];
  assign cout   = total[W];
  assign a_msb  = a[W-1];
  assign bx_msb = b_eff[W-1];
endmodule

// File: rtl/simd_sat_clamp.sv
module simd_sat_clamp
  import simd_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [N*W-1:0] raw,
  input  logic [N-1:0]   cout,
  input  logic [N-1:0]   a_msb,
  input  logic [N-1:0]   bx_msb,
  input  logic [1:0]     lane_sel,
  input  logic [1:0]     mode,
  input  logic           sub,
  output logic [N*W-1:0] res,
  output logic [N-1:0]   lane_ovf
);
  always_comb begin
    res      = raw;
    lane_ovf = '0;
    for (int unsigned k = 0; k < N; k++) begin
      int unsigned top;
      logic        s_ovf;
      logic        u_ovf;
      top   = lane_top_slice(k, lane_sel);
      s_ovf = (a_msb[top] == bx_msb[top]) && (raw[top*W + W - 1] != a_msb[top]);
      u_ovf = sub ? ~cout[top] : cout[top];
      case (mode)
        2'd1: begin
          lane_ovf[k] = s_ovf;
          if (s_ovf) res[k*W +: W] = ssat_slice(a_msb[top], top == k);
        end
        2'd2: begin
          lane_ovf[k] = u_ovf;
          if (u_ovf) res[k*W +: W] = sub ? {W{1'b0}} : {W{1'b1}};
        end
        default: lane_ovf[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        lane_sel,
  input  logic              op_sub,
  input  logic [1:0]        arith_mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int N = DATA_W / SLICE_W;

  logic [N-1:0]      carry_in;
  logic [N-1:0]      carry_out;
  logic [N-1:0]      a_msb;
  logic [N-1:0]      bx_msb;
  logic [DATA_W-1:0] raw_sum;
  logic [DATA_W-1:0] sat_res;
  logic [N-1:0]      lane_ovf;
  logic              mode_ssat;
  logic              mode_usat;

  assign mode_ssat = (arith_mode == ARITH_SSAT);
  assign mode_usat = (arith_mode == ARITH_USAT);

  for (genvar k = 0; k < N; k++) begin : g_slice
    if (k == 0) begin : g_first
      assign carry_in[k] = op_sub;
    end else begin : g_rest
      assign carry_in[k] = is_lane_start(k, lane_sel) ? op_sub : carry_out[k-1];
    end

    simd_add_slice #(.W(SLICE_W)) i_slice (
      .a      (in_a[k*SLICE_W +: SLICE_W]),
      .b      (in_b[k*SLICE_W +: SLICE_W]),
      .sub    (op_sub),
      .cin    (carry_in[k]),
      .sum    (raw_sum[k*SLICE_W +: SLICE_W]),
      .cout   (carry_out[k]),
      .a_msb  (a_msb[k]),
      .bx_msb (bx_msb[k])
    );
  end

  simd_sat_clamp #(.N(N), .W(SLICE_W)) i_clamp (
    .raw      (raw_sum),
    .cout     (carry_out),
    .a_msb    (a_msb),
    .bx_msb   (bx_msb),
    .lane_sel (lane_sel),
    .mode     (arith_mode),
    .sub      (op_sub),
    .res      (sat_res),
    .lane_ovf (lane_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sat_res;
    end
  end

  // R7: valid travels with exactly one cycle of latency
  p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  // R4: wraparound mode leaves the segmented sum untouched
  p_wrap_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_ssat && !mode_usat) |=> (out_data == $past(raw_sum)));

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R1: a slice whose lane did not overflow keeps its raw value
    p_nosat_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !lane_ovf[k]) |=>
        (out_data[k*SLICE_W +: SLICE_W] == $past(raw_sum[k*SLICE_W +: SLICE_W])));
    // R5: a signed clamp writes only limit patterns
    p_ssat_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_ssat && lane_ovf[k]) |=>
        (out_data[k*SLICE_W +: SLICE_W] inside {8'h00, 8'hFF, 8'h7F, 8'h80}));
    // R6: an unsigned clamp writes zero or all ones
    p_usat_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_usat && lane_ovf[k]) |=>
        (out_data[k*SLICE_W +: SLICE_W] inside {8'h00, 8'hFF}));
  end
endmodule

// File: tb/test_simd_sat_adder.sv
module test_simd_sat_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [1:0]  lane_sel = '0;
  logic        op_sub = 1'b0;
  logic [1:0]  arith_mode = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [63:0] held = '0;

  always #5 clk = ~clk;

  simd_sat_adder i_simd_sat_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .lane_sel(lane_sel), .op_sub(op_sub), .arith_mode(arith_mode),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Lane-by-lane model using wide signed integers and explicit clamp limits.
  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] sel, input logic sub,
                                        input logic [1:0] mode);
    int lw;
    logic [63:0] r;
    longint mask;
    lw = (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : 32;
    mask = (longint'(1) <<< lw) - 1;
    r = '0;
    for (int i = 0; i < 64 / lw; i++) begin
      longint ua, ub, sa, sb, v;
      ua = longint'(a >> (i * lw)) & mask;
      ub = longint'(b >> (i * lw)) & mask;
      sa = ua[lw-1] ? ua - (longint'(1) <<< lw) : ua;
      sb = ub[lw-1] ? ub - (longint'(1) <<< lw) : ub;
      if (mode == 2'd1) begin
        v = sub ? sa - sb : sa + sb;
        if (v > (longint'(1) <<< (lw - 1)) - 1) v = (longint'(1) <<< (lw - 1)) - 1;
        if (v < -(longint'(1) <<< (lw - 1))) v = -(longint'(1) <<< (lw - 1));
      end else if (mode == 2'd2) begin
        v = sub ? ua - ub : ua + ub;
        if (v > mask) v = mask;
        if (v < 0) v = 0;
      end else begin
        v = sub ? ua - ub : ua + ub;
      end
      r = r | (64'(v & mask) << (i * lw));
    end
    return r;
  endfunction

  task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                      input logic [1:0] sel, input logic sub, input logic [1:0] mode,
                      input string req);
    logic [63:0] exp;
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; lane_sel = sel; op_sub = sub; arith_mode = mode;
    exp = v ? model(a, b, sel, sub, mode) : held;
    @(negedge clk);
    n_checks++;
    if (out_valid !== v || out_data !== exp) begin
      n_fail++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h", req,
               out_valid, out_data, v, exp);
    end
    held = exp;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;  // R8 reset state
    if (out_valid !== 1'b0 || out_data !== 64'd0) begin
      n_fail++;
      $display("FAIL R8: valid=%0b data=%h expected valid=0 data=0", out_valid, out_data);
    end
    rst_n = 1'b1;

    // R1: byte lanes, carries stop at each byte; lane 0 in the low bits
    step(1, 64'h01FF_7F80_FF00_1234, 64'h0101_0180_0100_FF02, 2'd0, 0, 2'd0, "R1");
    step(1, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 2'd0, 0, 2'd0, "R1");
    step(1, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'd0, 1, 2'd0, "R1");
    // R2: 16-bit lanes, carry within lane only
    step(1, 64'hFFFF_00FF_7FFF_1234, 64'h0001_0001_0001_EDCC, 2'd1, 0, 2'd0, "R2");
    step(1, 64'h0000_0100_8000_0000, 64'h0001_0001_0001_0001, 2'd1, 1, 2'd0, "R2");
    // R3: 32-bit lanes, both encodings
    step(1, 64'hFFFF_FFFF_00FF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 0, 2'd0, "R3");
    step(1, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_0001, 2'd3, 1, 2'd0, "R3");
    // R4: wraparound, alternate encoding
    step(1, 64'h7F7F_7F7F_0000_0000, 64'h0101_0101_0101_0101, 2'd0, 0, 2'd3, "R4");
    step(1, 64'h8000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'd2, 1, 2'd3, "R4");
    // R5: signed saturation in every lane width
    step(1, 64'h7F80_7F80_0102_7F80, 64'h0101_FFFF_0101_0001, 2'd0, 0, 2'd1, "R5");
    step(1, 64'h8000_7FFF_8000_7FFF, 64'h0001_FFFF_FFFF_0001, 2'd1, 1, 2'd1, "R5");
    step(1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 2'd2, 0, 2'd1, "R5");
    step(1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 2'd2, 1, 2'd1, "R5");
    // R6: unsigned saturation in every lane width
    step(1, 64'hFF00_FE10_0180_FFFF, 64'h0100_0110_FF80_0001, 2'd0, 0, 2'd2, "R6");
    step(1, 64'h0000_0005_1000_0001, 64'h0001_0003_2000_0002, 2'd0, 1, 2'd2, "R6");
    step(1, 64'hFFFF_0001_8000_0100, 64'h0001_0002_8000_0001, 2'd1, 0, 2'd2, "R6");
    step(1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 1, 2'd2, "R6");
    // R7: idle cycles hold the result while inputs change
    step(0, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 2'd0, 0, 2'd0, "R7");
    step(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1, 2'd1, "R7");
    step(1, 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 2'd1, 0, 2'd0, "R7");

    for (int i = 0; i < 600; i++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 3) != 0), {$urandom, $urandom}, {$urandom, $urandom},
           2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), m,
           (m == 2'd1) ? "R5" : (m == 2'd2) ? "R6" : "R4");
    end

    // R8: reset clears the registers again
    @(negedge clk);
    in_valid = 1'b1;
    rst_n = 1'b0;
    #1;
    n_checks++;
    if (out_valid !== 1'b0 || out_data !== 64'd0) begin
      n_fail++;
      $display("FAIL R8: valid=%0b data=%h expected valid=0 data=0", out_valid, out_data);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule